// File: doc/BRIEF.md
# Overclock Guard Watchdog with Frequency Fallback

This block guards an attempt to run a clock synthesizer at a new frequency. The host first loads a fallback frequency-select code, a signed step offset, a timeout in whole seconds and finally the guard enable. It then writes the frequency code it wants to try. If the host does not confirm the new setting by clearing the enable before the timeout runs out, the block drives an active-low system reset pulse. It also drops its own enable and moves the effective frequency selection to the fallback code. If a second timeout happens while the fallback code is in use, the selection drops further, to the frequency strap value latched at power-up.

The block also forms the effective 5-bit frequency-select code and the signed step offset that the synthesizer consumes. The code comes either from the register field or from the latched straps. The offset is the sign-magnitude register byte turned into two's complement. The one-second time base is a prescaler on the reference clock, and its divide value is a parameter.

Top module: `clk_guard_wdt`

## Requirements
- R1: After reset `wd_rst_n` is 1 and `wd_en` is 0. The register select bit is 0, so `fs_eff` equals `strap_fs`.
- R2: A pulse on `cfg_fs_wr` loads `cfg_fs` and `cfg_sw_sel` into the frequency register. In the target stage `fs_eff` is the register code when the select bit is 1, and `strap_fs` when it is 0.
- R3: `ofs_code` is sign-magnitude, with bit 7 as the sign (1 means negative) and bits 6:0 as the magnitude. `step_ofs` is the same value in two's complement, range -127..+127. Negative zero (8'h80) gives 0.
- R4: A pulse on `wd_en_wr` with `wd_en_val`=1 sets `wd_en` and restarts the count from zero, even when the guard is already running. The guard expires TICK_DIV×T clock edges after that write, where T is `wd_tmo` and a value of 0 is treated as 1. On expiry `wd_en` clears by itself.
- R5: On expiry `wd_rst_n` goes low for exactly RST_LEN clock cycles and then returns to 1.
- R6: A pulse on `wd_en_wr` with `wd_en_val`=0 before expiry stops and clears the count. No reset pulse follows and the frequency selection does not change.
- R7: An expiry in the target stage switches `fs_eff` to `fb_fs`.
- R8: A `host_ok` pulse while the fallback is in use copies `fb_fs` into the register with the select bit set, and returns the block to the target stage. A later change of `fb_fs` no longer moves `fs_eff`, and a later expiry falls back to the new `fb_fs`.
- R9: An expiry while the fallback is in use switches `fs_eff` to `strap_fs`.
- R10: A `host_ok` pulse outside the fallback stage has no effect on `fs_eff`.
- R11: A `cfg_fs_wr` pulse in any stage returns the block to the target stage, so that `fs_eff` follows the register again.
- R12: An expiry while the strap setting is in use leaves `fs_eff` at `strap_fs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_en_wr | input | 1 | Write strobe for the guard enable |
| wd_en_val | input | 1 | Enable value written by `wd_en_wr` |
| wd_tmo | input | TMO_W | Timeout in seconds (0 acts as 1) |
| cfg_fs_wr | input | 1 | Write strobe for the frequency register |
| cfg_fs | input | 5 | Frequency code to store |
| cfg_sw_sel | input | 1 | Source select to store (1 = register, 0 = strap) |
| fb_fs | input | 5 | Fallback frequency code |
| strap_fs | input | 5 | Latched power-up strap code |
| host_ok | input | 1 | Host confirms that the fallback setting works |
| ofs_code | input | 8 | Sign-magnitude linear step offset |
| wd_rst_n | output | 1 | Active-low system reset pulse |
| wd_en | output | 1 | Current guard enable |
| fs_eff | output | 5 | Effective frequency-select code |
| step_ofs | output | 8 | Signed step offset, two's complement |

## Verification
The hardest case to reach is the three-level chain of stages: a first expiry, then either a confirmation or a second expiry, then a further expiry at the strap level. None of these stages can be read at a port. The stimulus walks the chain with short timeouts and with codes that differ for the register, the fallback and the straps, so each stage is identified by `fs_eff` alone. Changing `fb_fs` after a confirmation shows that the copy into the register took place. Re-arming in the middle of a count and writing a zero timeout check the restart and the minimum timeout to the exact cycle.

// File: rtl/cgw_pkg.sv
package cgw_pkg;
    localparam int FS_W = 5;

    typedef enum logic [1:0] {
        STG_TARGET   = 2'd0,
        STG_FALLBACK = 2'd1,
        STG_STRAP    = 2'd2
    } stage_e;
endpackage

// File: rtl/cgw_tick_gen.sv
module cgw_tick_gen #(
    parameter int DIV = 14318180
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && (pre_q == LAST);
        pre_d = pre_q + 1'b1;
        if (clr || !run || pre_q == LAST) begin
            pre_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/cgw_ofs_conv.sv
module cgw_ofs_conv (
    input  logic [7:0]        code,
    output logic signed [7:0] value
);
    logic signed [7:0] mag;

    always_comb begin
        mag   = $signed({1'b0, code[6:0]});
        value = code[7] ? -mag : mag;
    end
endmodule

// File: rtl/cgw_fs_pick.sv
module cgw_fs_pick
    import cgw_pkg::*;
(
    input  stage_e          stage,
    input  logic            sw_sel,
    input  logic [FS_W-1:0] reg_fs,
    input  logic [FS_W-1:0] fb_fs,
    input  logic [FS_W-1:0] strap_fs,
    output logic [FS_W-1:0] fs
);
    always_comb begin
        unique case (stage)
            STG_FALLBACK: fs = fb_fs;
            STG_STRAP:    fs = strap_fs;
            default:      fs = sw_sel ? reg_fs : strap_fs;
        endcase
    end
endmodule

// File: rtl/clk_guard_wdt.sv
module clk_guard_wdt
    import cgw_pkg::*;
#(
    parameter int TICK_DIV = 14318180,
    parameter int RST_LEN  = 16,
    parameter int TMO_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_en_wr,
    input  logic              wd_en_val,
    input  logic [TMO_W-1:0]  wd_tmo,
    input  logic              cfg_fs_wr,
    input  logic [4:0]        cfg_fs,
    input  logic              cfg_sw_sel,
    input  logic [4:0]        fb_fs,
    input  logic [4:0]        strap_fs,
    input  logic              host_ok,
    input  logic [7:0]        ofs_code,
    output logic              wd_rst_n,
    output logic              wd_en,
    output logic [4:0]        fs_eff,
    output logic signed [7:0] step_ofs
);
    localparam int RC_W = $clog2(RST_LEN + 1);
    localparam int SC_W = TMO_W + 1;

    typedef struct packed {
        logic            en;
        logic [TMO_W-1:0] sec;
        logic [RC_W-1:0] rcnt;
        stage_e          stage;
        logic [FS_W-1:0] reg_fs;
        logic            sw_sel;
    } guard_t;

    guard_t s_d, s_q;
    logic   tick;
    logic   expire;
    logic [SC_W-1:0] tmo_eff;
    logic [SC_W-1:0] sec_inc;

    cgw_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wd_en_wr),
        .run  (s_q.en),
        .tick (tick)
    );

    always_comb begin
        s_d     = s_q;
        tmo_eff = (wd_tmo == '0) ? SC_W'(1) : {1'b0, wd_tmo};
        sec_inc = {1'b0, s_q.sec} + 1'b1;
        expire  = s_q.en && tick && (sec_inc >= tmo_eff);

        if (s_q.rcnt != '0) begin
            s_d.rcnt = s_q.rcnt - 1'b1;
        end
        if (s_q.en && tick) begin
            s_d.sec = sec_inc[TMO_W-1:0];
        end
        if (expire) begin
            s_d.en    = 1'b0;
            s_d.sec   = '0;
            s_d.rcnt  = RC_W'(RST_LEN);
            s_d.stage = (s_q.stage == STG_TARGET) ? STG_FALLBACK : STG_STRAP;
        end
        if (wd_en_wr) begin
            s_d.en  = wd_en_val;
            s_d.sec = '0;
        end
        if (cfg_fs_wr) begin
            s_d.reg_fs = cfg_fs;
            s_d.sw_sel = cfg_sw_sel;
            s_d.stage  = STG_TARGET;
        end else if (host_ok && s_q.stage == STG_FALLBACK) begin
            s_d.reg_fs = fb_fs;
            s_d.sw_sel = 1'b1;
            s_d.stage  = STG_TARGET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{en: 1'b0, sec: '0, rcnt: '0, stage: STG_TARGET,
                     reg_fs: '0, sw_sel: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    cgw_fs_pick u_pick (
        .stage   (s_q.stage),
        .sw_sel  (s_q.sw_sel),
        .reg_fs  (s_q.reg_fs),
        .fb_fs   (fb_fs),
        .strap_fs(strap_fs),
        .fs      (fs_eff)
    );

    cgw_ofs_conv u_ofs (
        .code (ofs_code),
        .value(step_ofs)
    );

    assign wd_rst_n = (s_q.rcnt == '0);
    assign wd_en    = s_q.en;
endmodule

// File: rtl/cgw_guard_chk.sv
module cgw_guard_chk #(
    parameter int RST_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wd_en_wr,
    input logic              cfg_fs_wr,
    input logic              host_ok,
    input logic [4:0]        fb_fs,
    input logic [4:0]        strap_fs,
    input logic [7:0]        ofs_code,
    input logic              wd_rst_n,
    input logic              wd_en,
    input logic [4:0]        fs_eff,
    input logic signed [7:0] step_ofs
);
    localparam int LW = $clog2(RST_LEN + 2);
    logic [LW-1:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  lo_cnt <= '0;
        else if (wd_rst_n)                           lo_cnt <= '0;
        else if (lo_cnt != LW'(RST_LEN + 1))         lo_cnt <= lo_cnt + 1'b1;
    end

    // R4: expiry drops the enable unless the host rewrote it in that cycle
    a_r4_expiry_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) && !$past(wd_en_wr) |-> !wd_en);

    // R5: the reset pulse is never shorter than RST_LEN cycles
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_n) |-> (lo_cnt >= LW'(RST_LEN)));

    // R3: two's-complement result stays in -127..+127 and keeps the sign
    a_r3_offset_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_code[6:0] != 7'd0) |-> (step_ofs != 8'sh80) && (step_ofs[7] == ofs_code[7]));

    // R2: with no write, confirm, expiry or source change the selection holds
    a_r2_fs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wd_en) && !$past(cfg_fs_wr) && !$past(host_ok)
        && $stable(fb_fs) && $stable(strap_fs) |-> $stable(fs_eff));

    // R7, R9: an expiry selects the fallback code or the strap code
    a_r7_expiry_target: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) && !$past(cfg_fs_wr) && !$past(host_ok)
        |-> (fs_eff == fb_fs) || (fs_eff == strap_fs));
endmodule

bind clk_guard_wdt cgw_guard_chk #(.RST_LEN(RST_LEN)) u_guard_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wd_en_wr (wd_en_wr),
    .cfg_fs_wr(cfg_fs_wr),
    .host_ok  (host_ok),
    .fb_fs    (fb_fs),
    .strap_fs (strap_fs),
    .ofs_code (ofs_code),
    .wd_rst_n (wd_rst_n),
    .wd_en    (wd_en),
    .fs_eff   (fs_eff),
    .step_ofs (step_ofs)
);

// File: tb/sim_clk_guard_wdt.sv
`timescale 1ns/1ps
module sim_clk_guard_wdt;
    localparam int D = 4;
    localparam int L = 3;
    localparam int NV = 8;
    localparam logic [15:0] OFS_VEC [NV] = '{
        16'h00_00, 16'h05_05, 16'h7F_7F, 16'h80_00,
        16'h81_FF, 16'h9B_E5, 16'hFF_81, 16'h1B_1B
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wd_en_wr = 0, wd_en_val = 0, cfg_fs_wr = 0, cfg_sw_sel = 0, host_ok = 0;
    logic [5:0] wd_tmo = 6'd1;
    logic [4:0] cfg_fs = 0, fb_fs = 5'h07, strap_fs = 5'h13;
    logic [7:0] ofs_code = 0;
    logic wd_rst_n, wd_en;
    logic [4:0] fs_eff;
    logic signed [7:0] step_ofs;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    clk_guard_wdt #(.TICK_DIV(D), .RST_LEN(L), .TMO_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .wd_en_wr(wd_en_wr), .wd_en_val(wd_en_val),
        .wd_tmo(wd_tmo), .cfg_fs_wr(cfg_fs_wr), .cfg_fs(cfg_fs),
        .cfg_sw_sel(cfg_sw_sel), .fb_fs(fb_fs), .strap_fs(strap_fs),
        .host_ok(host_ok), .ofs_code(ofs_code), .wd_rst_n(wd_rst_n),
        .wd_en(wd_en), .fs_eff(fs_eff), .step_ofs(step_ofs));

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_en(logic v, logic [5:0] t);
        @(negedge clk); wd_tmo = t; wd_en_val = v; wd_en_wr = 1;
        @(negedge clk); wd_en_wr = 0;
    endtask

    task automatic wr_fs(logic [4:0] f, logic s);
        @(negedge clk); cfg_fs = f; cfg_sw_sel = s; cfg_fs_wr = 1;
        @(negedge clk); cfg_fs_wr = 0;
    endtask

    task automatic pulse_ok();
        @(negedge clk); host_ok = 1;
        @(negedge clk); host_ok = 0;
    endtask

    // called right after the negedge that follows the enabling edge
    task automatic expect_expiry(string req, int t);
        repeat (t * D - 1) @(negedge clk);
        chk(req, wd_rst_n, 1);
        @(negedge clk);
        chk(req, wd_rst_n, 0);
        chk(req, wd_en, 0);
        repeat (L - 1) @(negedge clk);
        chk("R5", wd_rst_n, 0);
        @(negedge clk);
        chk("R5", wd_rst_n, 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", wd_rst_n, 1);
        chk("R1", wd_en, 0);
        chk("R1", fs_eff, 5'h13);
        rst_n = 1;
        @(negedge clk);

        // R3 offset vectors
        for (int i = 0; i < NV; i++) begin
            ofs_code = OFS_VEC[i][15:8];
            #1;
            chk("R3", step_ofs, $signed(OFS_VEC[i][7:0]));
        end

        // R2 source select
        wr_fs(5'h0A, 1);
        chk("R2", fs_eff, 5'h0A);
        wr_fs(5'h0A, 0);
        chk("R2", fs_eff, 5'h13);
        wr_fs(5'h0A, 1);

        // R4/R5/R7 first expiry
        wr_en(1, 6'd2);
        chk("R4", wd_en, 1);
        expect_expiry("R4", 2);
        chk("R7", fs_eff, 5'h07);

        // R9 second expiry, R12 third
        wr_en(1, 6'd1);
        expect_expiry("R9", 1);
        chk("R9", fs_eff, 5'h13);
        wr_en(1, 6'd1);
        expect_expiry("R12", 1);
        chk("R12", fs_eff, 5'h13);

        // R11 register write returns to target
        wr_fs(5'h0A, 1);
        chk("R11", fs_eff, 5'h0A);

        // R6 disable before expiry
        wr_en(1, 6'd3);
        repeat (2 * D) @(negedge clk);
        wr_en(0, 6'd3);
        begin
            int lows = 0;
            for (int k = 0; k < 4 * D; k++) begin
                @(negedge clk);
                if (!wd_rst_n) lows++;
            end
            chk("R6", lows, 0);
        end
        chk("R6", wd_en, 0);
        chk("R6", fs_eff, 5'h0A);

        // R10 confirm outside fallback ignored
        fb_fs = 5'h1F;
        pulse_ok();
        chk("R10", fs_eff, 5'h0A);

        // R8 confirm in fallback copies code
        wr_en(1, 6'd1);
        expect_expiry("R7", 1);
        chk("R7", fs_eff, 5'h1F);
        pulse_ok();
        fb_fs = 5'h02;
        #1;
        chk("R8", fs_eff, 5'h1F);
        wr_en(1, 6'd1);
        expect_expiry("R8", 1);
        chk("R8", fs_eff, 5'h02);

        // R4 zero timeout acts as one second
        wr_fs(5'h0A, 1);
        wr_en(1, 6'd0);
        expect_expiry("R4", 1);

        // R4 rewrite of enable restarts the count
        wr_fs(5'h0A, 1);
        wr_en(1, 6'd2);
        repeat (D) @(negedge clk);
        wr_en(1, 6'd2);
        expect_expiry("R4", 2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule